// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block sits on a two-wire serial bus as a target and lets a bus host read and write an internal register space. Register addresses are 16 bits wide. The host sends them as two bytes, high byte first. A fast system clock oversamples the clock and data lines. Each line passes through a two-flop synchronizer and a majority-free "all samples agree" glitch filter before the logic looks for bus edges. The block never drives the clock line. On the data line it only pulls low, through an output enable, so an open-drain pad outside the block does the driving.

Two strap inputs are captured while reset is high and give the device address. The top five address bits are always `11000`. With both straps low the serial bus is not used at all: the block raises a mode flag for a separate SPI engine and ignores all bus traffic. A write is: start, device address with write, address high byte, address low byte, then data bytes. A read is: start, device address with write, the two address bytes, repeated start, device address with read, then data bytes. The register address advances by one after every data byte, in both directions.

Top module: `i2c_reg_target`

## Requirements
- R1: The straps are captured only while `rst` is high. A captured value of `strap_b1`=0, `strap_b0`=0 sets `spi_sel`=1. In that mode `sda_oe` and `reg_we` stay 0 whatever happens on the bus. After reset `sda_oe` is 0.
- R2: The 7-bit device address is `{5'b11000, 2'(strap-1)}`, with strap = `{strap_b1,strap_b0}`. So 01 gives 0x60, 10 gives 0x61 and 11 gives 0x62. The address byte is acknowledged (SDA held low in the ninth clock) only when its upper seven bits match. Bit 0 of the address byte is the direction: 0 means write, 1 means read.
- R3: After an address byte that does not match, the target acknowledges nothing and writes nothing until the next start condition.
- R4: In a write, the two bytes after the address byte set `reg_addr[15:8]` and then `reg_addr[7:0]`. Each later byte gives exactly one one-cycle `reg_we` pulse, with `reg_wdata` holding the byte (MSB first on the wire) and `reg_addr` holding its register address. Every byte is acknowledged.
- R5: The register address increments by one after each data byte written or read, and wraps from 0xFFFF to 0x0000.
- R6: After a repeated start and a matching address byte with the read bit, the target sends `reg_rdata` for the current `reg_addr`, MSB first, one byte per data phase.
- R7: When the host does not acknowledge a read byte, the target stops driving SDA and stays released until the next start.
- R8: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. After a stop the target returns to idle with SDA released.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clocks has no effect on the transfer.
- R10: The target only begins pulling SDA low while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_b1 | input | 1 | Upper address strap |
| strap_b0 | input | 1 | Lower address strap |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| spi_sel | output | 1 | 1 when the straps select SPI mode |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The hardest state to reach from the ports is a read that starts at the top of the address space and runs on past the host's NACK. It is only reached after a full write-direction address phase, a repeated start and a change of direction. The bench gets there by setting the base address to 0xFFFF for one candidate address per strap setting. It reads three bytes across the wrap and then clocks a fourth byte after the NACK, which must come back as all ones. The same sweep puts a one-clock pulse on both lines in the middle of a data bit. That pulse would look like a false start or stop if the filter did not reject it.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    localparam int REG_AW = 16;
    localparam int DW     = 8;
    localparam logic [3:0] ACK_SLOT = 4'd8;
    localparam logic [3:0] END_SLOT = 4'd9;
    localparam logic [4:0] DEV_HI   = 5'b11000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [6:0] strap_to_dev(input logic [1:0] strap);
        logic [1:0] low2;
        low2 = strap - 2'd1;
        return {DEV_HI, low2};
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            filt   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                filt <= 1'b1;
            else if (~|hist_q)
                filt <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_reg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [6:0]        dev_addr,
    input  bus_ev_t           ev,
    input  logic              sda_f,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              reg_we,
    input  logic [DW-1:0]     reg_rdata
);
    phase_e       st;
    logic [3:0]   bitcnt;
    logic [DW-1:0] shreg;
    logic         rw;
    logic         host_nack;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st        <= PH_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            rw        <= 1'b0;
            host_nack <= 1'b0;
            sda_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (ev.start) begin
                st     <= PH_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= PH_IDLE;
                sda_oe <= 1'b0;
            end else if (st != PH_IDLE) begin
                if (ev.rise) begin
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt < ACK_SLOT && st != PH_RD)
                        shreg <= {shreg[DW-2:0], sda_f};
                    if (bitcnt == ACK_SLOT)
                        host_nack <= sda_f;
                end else if (ev.fall) begin
                    if (bitcnt == ACK_SLOT) begin
                        unique case (st)
                            PH_DEV: begin
                                if (shreg[7:1] == dev_addr) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                end else begin
                                    st <= PH_IDLE;
                                end
                            end
                            PH_AHI: begin
                                reg_addr[15:8] <= shreg;
                                sda_oe         <= 1'b1;
                            end
                            PH_ALO: begin
                                reg_addr[7:0] <= shreg;
                                sda_oe        <= 1'b1;
                            end
                            PH_WR: begin
                                reg_wdata <= shreg;
                                reg_we    <= 1'b1;
                                sda_oe    <= 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (bitcnt == END_SLOT) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        unique case (st)
                            PH_DEV: begin
                                if (rw) begin
                                    st       <= PH_RD;
                                    shreg    <= reg_rdata;
                                    sda_oe   <= ~reg_rdata[7];
                                    reg_addr <= reg_addr + 1'b1;
                                end else begin
                                    st <= PH_AHI;
                                end
                            end
                            PH_AHI: st <= PH_ALO;
                            PH_ALO: st <= PH_WR;
                            PH_WR:  reg_addr <= reg_addr + 1'b1;
                            PH_RD: begin
                                if (host_nack) begin
                                    st <= PH_IDLE;
                                end else begin
                                    shreg    <= reg_rdata;
                                    sda_oe   <= ~reg_rdata[7];
                                    reg_addr <= reg_addr + 1'b1;
                                end
                            end
                            default: st <= PH_IDLE;
                        endcase
                    end else if (st == PH_RD && bitcnt != 4'd0) begin
                        shreg  <= {shreg[DW-2:0], 1'b0};
                        sda_oe <= ~shreg[DW-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_reg_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_b1,
    input  logic              strap_b0,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              spi_sel,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DW-1:0]     reg_wdata,
    output logic              reg_we,
    input  logic [DW-1:0]     reg_rdata
);
    localparam int NLINES = 2;

    logic [1:0]        strap_q;
    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_filt;
    logic              scl_f, sda_f;
    bus_ev_t           ev;

    always_ff @(posedge clk) begin
        if (rst)
            strap_q <= {strap_b1, strap_b0};
    end

    assign spi_sel  = (strap_q == 2'b00);
    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (line_raw[g]),
            .filt (line_filt[g])
        );
    end

    assign scl_f = line_filt[1];
    assign sda_f = line_filt[0];

    i2c_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .ev    (ev)
    );

    i2c_tgt_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .enable    (~spi_sel),
        .dev_addr  (strap_to_dev(strap_q)),
        .ev        (ev),
        .sda_f     (sda_f),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
    import i2c_reg_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    spi_sel,
    input logic    sda_oe,
    input logic    reg_we,
    input logic    scl_f,
    input bus_ev_t ev
);
    a_r1_spi_quiet: assert property (@(posedge clk) disable iff (rst)
        spi_sel |-> (!sda_oe && !reg_we));

    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r4_we_scl_low: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !scl_f);

    a_r8_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .spi_sel (spi_sel),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .scl_f   (scl_f),
    .ev      (ev)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s1 = 1'b0, s0 = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        sda_oe, spi_sel, reg_we;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int          we_n = 0;
    logic [15:0] we_a [0:15];
    logic [7:0]  we_d [0:15];

    always #2 clk = ~clk;

    function automatic logic [7:0] rd_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign reg_rdata = rd_f(reg_addr);

    i2c_reg_target dut (
        .clk(clk), .rst(rst), .strap_b1(s1), .strap_b0(s0),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe), .spi_sel(spi_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    always @(negedge clk) begin
        if (!rst && reg_we && we_n < 16) begin
            we_a[we_n] = reg_addr;
            we_d[we_n] = reg_wdata;
            we_n = we_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(Q / 2);
            if (glitch) begin
                scl_m = 1'b0; sda_m = ~sda_m; wq(1);
                scl_m = 1'b1; sda_m = b[i];
            end
            wq(Q / 2);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q / 2);
        ack = !sda_bus;
        wq(Q / 2);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_byte(input bit send_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q / 2);
            b[i] = sda_bus;
            wq(Q / 2);
            scl_m = 1'b0;
        end
        wq(Q / 2);
        sda_m = send_ack ? 1'b0 : 1'b1; wq(Q / 2);
        scl_m = 1'b1; wq(Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit          ack;
        bit          match;
        logic [7:0]  rb, c, d0, d1;
        logic [15:0] base;
        for (int strap = 0; strap < 4; strap++) begin
            {s1, s0} = 2'(strap);
            rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
            wq(5);
            rst = 1'b0;
            wq(3);
            {s1, s0} = ~2'(strap);
            chk(spi_sel == (strap == 0), "R1 spi_sel", spi_sel, strap == 0);
            chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
            for (int cand = 8'h60; cand <= 8'h63; cand++) begin
                c = 8'(cand);
                match = (strap != 0) && (cand == 8'h60 + strap - 1);
                base = (cand == 8'h62) ? 16'hFFFF : {c, 6'd0, 2'(strap)};
                d0 = c ^ base[7:0] ^ 8'h96;
                d1 = ~d0;
                we_n = 0;
                bus_start();
                wr_byte({c[6:0], 1'b0}, 1'b0, ack);
                chk(ack == match, "R2 address ack", ack, match);
                wr_byte(base[15:8], 1'b0, ack);
                chk(ack == match, "R3 ahi ack", ack, match);
                wr_byte(base[7:0], 1'b0, ack);
                chk(ack == match, "R3 alo ack", ack, match);
                wr_byte(d0, match && strap == 3, ack);
                chk(ack == match, "R4 data0 ack", ack, match);
                wr_byte(d1, 1'b0, ack);
                chk(ack == match, "R4 data1 ack", ack, match);
                bus_stop();
                chk(we_n == (match ? 2 : 0), "R3 R4 write count", we_n, match ? 2 : 0);
                chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
                if (match) begin
                    chk(we_a[0] == base, "R4 first write addr", we_a[0], base);
                    chk(we_d[0] == d0, "R9 R4 first write data", we_d[0], d0);
                    chk(we_a[1] == 16'(base + 16'd1), "R5 incremented addr",
                        we_a[1], 16'(base + 16'd1));
                    chk(we_d[1] == d1, "R4 second write data", we_d[1], d1);

                    bus_start();
                    wr_byte({c[6:0], 1'b0}, 1'b0, ack);
                    wr_byte(base[15:8], 1'b0, ack);
                    wr_byte(base[7:0], 1'b0, ack);
                    bus_rstart();
                    wr_byte({c[6:0], 1'b1}, 1'b0, ack);
                    chk(ack == 1'b1, "R6 read address ack", ack, 1);
                    for (int k = 0; k < 3; k++) begin
                        rd_byte(k < 2, rb);
                        chk(rb == rd_f(16'(base + 16'(k))), "R6 R5 read data", rb,
                            rd_f(16'(base + 16'(k))));
                    end
                    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
                    rd_byte(1'b0, rb);
                    chk(rb == 8'hFF, "R7 no drive after nack", rb, 8'hFF);
                    bus_stop();
                    chk(sda_oe == 1'b0, "R8 idle after stop", sda_oe, 0);
                end
            end
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule